// File: doc/BRIEF.md
# Sleep-Aware Successive-Approximation Conversion Sequencer

This block is the digital sequencer for an 8-bit successive-approximation converter inside a microcontroller. A start request from software begins one conversion. The sequencer takes one sample period and then settles one bit per conversion-clock tick, starting from the most significant bit. On each decision it reads a comparator and keeps or drops the trial bit on the DAC code it drives. At the end it stores the code, drops its busy flag and raises an interrupt flag.

The block also decides what a conversion does when the core enters sleep. The outcome depends on the conversion clock source. With the internal RC source, selected by `clk_sel == 2'b11`, the conversion runs to the end. It then either asks the core to wake or, if the interrupt is masked, powers the converter down. With any other source, entering sleep aborts the conversion and powers the converter down. The enable input is never altered. Its effect is shown through `conv_powered`, which drops while the converter has switched itself off.

A system reset cancels any conversion and clears the control state but leaves the stored result alone. Only the separate power-on reset clears the result.

Top module: `adc_sleep_seq`

## Requirements
- R1: While and after system reset the outputs are: `busy` 0, `irq_flag` 0, `wake_req` 0 and `dac_code` 0. `conv_powered` equals `enable`.
- R2: Power-on reset (`por_n` low) clears `result` to 8'h00. System reset (`rst_n` low) leaves `result` unchanged, even when it aborts a conversion.
- R3: A `go_set` pulse starts a conversion only when `enable` is 1 and `busy` is 0. `busy` is 1 after the accepting edge. A pulse while `enable` is 0 leaves `busy` at 0. A pulse while `busy` is 1 does not change the running conversion or its result.
- R4: With a clock source other than 2'b11, the first conversion tick after acceptance is the sample period. After that tick `dac_code` is 8'h80, with only the MSB set.
- R5: With `clk_sel` = 2'b11, the block waits START_DLY_CLKS clock cycles after acceptance before its sample period. Conversion ticks in that wait are ignored and `dac_code` stays 0.
- R6: Eight decision ticks follow the sample tick, MSB first. A decision keeps the trial bit when `cmp_in` is 1 and clears it when `cmp_in` is 0. With `cmp_in` = (input >= `dac_code`), the result is the input in LSB units clamped to 00h..FFh.
- R7: On the edge of the last decision, `busy` falls, `result` takes the final code and `irq_flag` is set. `irq_clr` clears `irq_flag`. A completion in the same cycle as `irq_clr` leaves the flag set.
- R8: `sleep_enter` with `clk_sel` != 2'b11 during a conversion aborts it. After that edge `busy` is 0, `irq_flag` is not set, `result` is unchanged and `conv_powered` is 0 while `enable` stays 1.
- R9: With `clk_sel` = 2'b11, a conversion continues through `sleep_enter`. If it finishes while asleep with `irq_en` = 1, `wake_req` is 1 until `sleep_exit`.
- R10: A conversion that finishes while asleep with `irq_en` = 0 sets `irq_flag`, keeps `wake_req` at 0 and drops `conv_powered`.
- R11: When `sleep_enter` with a non-RC source falls on the same edge as the last decision tick, the abort wins. No result is stored and `irq_flag` is not set.
- R12: The powered-down state ends on `sleep_exit`, on an accepted start, or when `enable` goes low. After that `conv_powered` follows `enable` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | System reset, asynchronous, active low |
| por_n | input | 1 | Power-on reset for the result register, active low |
| enable | input | 1 | Converter enable bit |
| go_set | input | 1 | One-cycle start request |
| clk_sel | input | 2 | Conversion clock source, 2'b11 = internal RC |
| sleep_enter | input | 1 | One-cycle strobe: core enters sleep |
| sleep_exit | input | 1 | One-cycle strobe: core leaves sleep |
| irq_en | input | 1 | Conversion interrupt enable |
| irq_clr | input | 1 | One-cycle clear of the interrupt flag |
| conv_tick | input | 1 | One-cycle conversion clock tick |
| cmp_in | input | 1 | Comparator: 1 when input >= DAC level |
| dac_code | output | 8 | Trial code to the DAC |
| busy | output | 1 | Conversion in progress |
| result | output | 8 | Last completed conversion code |
| irq_flag | output | 1 | Conversion-complete interrupt flag |
| wake_req | output | 1 | Wake-up request to the core |
| conv_powered | output | 1 | Converter currently powered |

## Verification
Two events can fall on the same clock edge: a sleep entry with a non-RC source, and the final bit decision of a conversion. The bench runs a conversion through its sample tick and seven decisions. It then raises `sleep_enter` and the eighth `conv_tick` together. The abort must win: `busy` low, `irq_flag` low, the earlier `result` kept and `conv_powered` low. A second overlap is also tested, a final decision on the same edge as `irq_clr`, where the flag must stay set.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

   localparam logic [1:0] CLKSRC_RC = 2'b11;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_HOLD   = 2'd1,
      PH_SAMPLE = 2'd2,
      PH_DECIDE = 2'd3
   } adc_phase_e;

endpackage

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
   import adcseq_pkg::*;
#(
   parameter int unsigned START_DLY_CLKS = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       go_set,
   input  logic       enable,
   input  logic [1:0] clk_sel,
   input  logic       sleep_enter,
   input  logic       conv_tick,
   input  logic       sar_last,
   output logic       busy,
   output logic       accept,
   output logic       abort,
   output logic       load_first,
   output logic       decide,
   output logic       done
);

   localparam bit HAS_HOLD = (START_DLY_CLKS > 0);
   localparam int unsigned CW = (START_DLY_CLKS > 1) ? $clog2(START_DLY_CLKS) : 1;

   adc_phase_e ph_q, ph_d;
   logic       rc_now;
   logic       hold_done;

   assign rc_now     = (clk_sel == CLKSRC_RC);
   assign busy       = (ph_q != PH_IDLE);
   assign abort      = sleep_enter && busy && !rc_now;
   assign accept     = go_set && enable && !busy && !(sleep_enter && !rc_now);
   assign load_first = (ph_q == PH_SAMPLE) && conv_tick && !abort;
   assign decide     = (ph_q == PH_DECIDE) && conv_tick && !abort;
   assign done       = decide && sar_last;

   generate
      if (HAS_HOLD) begin : g_hold
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (accept)
               cnt_q <= CW'(START_DLY_CLKS - 1);
            else if (ph_q == PH_HOLD && cnt_q != '0)
               cnt_q <= cnt_q - 1'b1;
         end
         assign hold_done = (cnt_q == '0);
      end else begin : g_nohold
         assign hold_done = 1'b1;
      end
   endgenerate

   always_comb begin
      ph_d = ph_q;
      unique case (ph_q)
         PH_IDLE:   if (accept) ph_d = (rc_now && HAS_HOLD) ? PH_HOLD : PH_SAMPLE;
         PH_HOLD:   if (hold_done) ph_d = PH_SAMPLE;
         PH_SAMPLE: if (load_first) ph_d = PH_DECIDE;
         PH_DECIDE: if (done) ph_d = PH_IDLE;
         default:   ph_d = PH_IDLE;
      endcase
      if (abort) ph_d = PH_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ph_q <= PH_IDLE;
      else        ph_q <= ph_d;
   end

   p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);

   p_abort_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_enter && busy && clk_sel != CLKSRC_RC) |=> !busy);

   p_go_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (go_set && !enable && !busy) |=> !busy);

   p_rc_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (HAS_HOLD && accept && clk_sel == CLKSRC_RC) |=> (ph_q == PH_HOLD));

   p_abort_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_enter && clk_sel != CLKSRC_RC && ph_q == PH_DECIDE) |-> !done);

endmodule

// File: rtl/adcseq_sar.sv
module adcseq_sar #(
   parameter int unsigned RES_BITS = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                por_n,
   input  logic                load_first,
   input  logic                decide,
   input  logic                clear,
   input  logic                cmp_in,
   output logic [RES_BITS-1:0] trial,
   output logic [RES_BITS-1:0] result,
   output logic                last
);

   localparam logic [RES_BITS-1:0] MSB_ONLY = {1'b1, {(RES_BITS-1){1'b0}}};

   logic [RES_BITS-1:0] trial_q, mask_q, kept;

   assign kept  = cmp_in ? trial_q : (trial_q & ~mask_q);
   assign trial = trial_q;
   assign last  = mask_q[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trial_q <= '0;
         mask_q  <= '0;
      end else if (clear) begin
         trial_q <= '0;
         mask_q  <= '0;
      end else if (load_first) begin
         trial_q <= MSB_ONLY;
         mask_q  <= MSB_ONLY;
      end else if (decide) begin
         if (mask_q[0]) begin
            trial_q <= '0;
            mask_q  <= '0;
         end else begin
            trial_q <= kept | (mask_q >> 1);
            mask_q  <= mask_q >> 1;
         end
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)
         result <= '0;
      else if (decide && mask_q[0])
         result <= kept;
   end

   p_mask_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(mask_q));

   p_result_hold_r2: assert property (@(posedge clk) disable iff (!por_n)
      !(decide && last) |=> $stable(result));

   p_first_trial_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (load_first && !clear) |=> (trial == MSB_ONLY));

endmodule

// File: rtl/adcseq_power.sv
module adcseq_power
   import adcseq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       enable,
   input  logic [1:0] clk_sel,
   input  logic       sleep_enter,
   input  logic       sleep_exit,
   input  logic       irq_en,
   input  logic       irq_clr,
   input  logic       accept,
   input  logic       done,
   output logic       irq_flag,
   output logic       wake_req,
   output logic       conv_powered
);

   logic asleep_q, off_q, off_set, off_clr;

   assign off_set = (sleep_enter && clk_sel != CLKSRC_RC) ||
                    (done && asleep_q && !irq_en);
   assign off_clr = !enable || sleep_exit || accept;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         asleep_q <= 1'b0;
         off_q    <= 1'b0;
         irq_flag <= 1'b0;
      end else begin
         if (sleep_enter)     asleep_q <= 1'b1;
         else if (sleep_exit) asleep_q <= 1'b0;

         if (off_set)      off_q <= 1'b1;
         else if (off_clr) off_q <= 1'b0;

         if (done)         irq_flag <= 1'b1;
         else if (irq_clr) irq_flag <= 1'b0;
      end
   end

   assign wake_req     = irq_flag && irq_en && asleep_q;
   assign conv_powered = enable && !off_q;

   p_irq_on_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> irq_flag);

   p_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && asleep_q && irq_en && !sleep_exit) |=> wake_req);

   p_sleep_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (done && asleep_q && !irq_en) |=> !conv_powered);

   p_abort_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_enter && clk_sel != CLKSRC_RC) |=> !conv_powered);

   p_wake_gone_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_exit && !sleep_enter) |=> !wake_req);

endmodule

// File: rtl/adc_sleep_seq.sv
module adc_sleep_seq #(
   parameter int unsigned RES_BITS       = 8,
   parameter int unsigned START_DLY_CLKS = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                por_n,
   input  logic                enable,
   input  logic                go_set,
   input  logic [1:0]          clk_sel,
   input  logic                sleep_enter,
   input  logic                sleep_exit,
   input  logic                irq_en,
   input  logic                irq_clr,
   input  logic                conv_tick,
   input  logic                cmp_in,
   output logic [RES_BITS-1:0] dac_code,
   output logic                busy,
   output logic [RES_BITS-1:0] result,
   output logic                irq_flag,
   output logic                wake_req,
   output logic                conv_powered
);

   generate
      if (RES_BITS < 2 || RES_BITS > 16) begin : g_bad_res
         $error("adc_sleep_seq: RES_BITS must lie in 2..16");
      end
      if (START_DLY_CLKS > 1024) begin : g_bad_dly
         $error("adc_sleep_seq: START_DLY_CLKS too large");
      end
   endgenerate

   logic accept, abort, load_first, decide, done, sar_last;

   adcseq_ctrl #(
      .START_DLY_CLKS(START_DLY_CLKS)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .go_set     (go_set),
      .enable     (enable),
      .clk_sel    (clk_sel),
      .sleep_enter(sleep_enter),
      .conv_tick  (conv_tick),
      .sar_last   (sar_last),
      .busy       (busy),
      .accept     (accept),
      .abort      (abort),
      .load_first (load_first),
      .decide     (decide),
      .done       (done)
   );

   adcseq_sar #(
      .RES_BITS(RES_BITS)
   ) u_sar (
      .clk       (clk),
      .rst_n     (rst_n),
      .por_n     (por_n),
      .load_first(load_first),
      .decide    (decide),
      .clear     (abort),
      .cmp_in    (cmp_in),
      .trial     (dac_code),
      .result    (result),
      .last      (sar_last)
   );

   adcseq_power u_power (
      .clk         (clk),
      .rst_n       (rst_n),
      .enable      (enable),
      .clk_sel     (clk_sel),
      .sleep_enter (sleep_enter),
      .sleep_exit  (sleep_exit),
      .irq_en      (irq_en),
      .irq_clr     (irq_clr),
      .accept      (accept),
      .done        (done),
      .irq_flag    (irq_flag),
      .wake_req    (wake_req),
      .conv_powered(conv_powered)
   );

endmodule

// File: tb/adc_sleep_seq_bench.sv
`timescale 1ns/1ps
module adc_sleep_seq_bench;

   localparam int DLY = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0, por_n = 1'b0;
   logic       enable = 1'b0, go_set = 1'b0, sleep_enter = 1'b0, sleep_exit = 1'b0;
   logic [1:0] clk_sel = 2'b00;
   logic       irq_en = 1'b0, irq_clr = 1'b0, conv_tick = 1'b0, cmp_in;
   logic [7:0] dac_code, result;
   logic       busy, irq_flag, wake_req, conv_powered;
   int         vin = 0;
   int         n_chk = 0, n_fail = 0, cycles = 0;

   always #10 clk = ~clk;

   assign cmp_in = (vin >= int'(dac_code));

   adc_sleep_seq #(.RES_BITS(8), .START_DLY_CLKS(DLY)) u_adc_sleep_seq (
      .clk(clk), .rst_n(rst_n), .por_n(por_n), .enable(enable), .go_set(go_set),
      .clk_sel(clk_sel), .sleep_enter(sleep_enter), .sleep_exit(sleep_exit),
      .irq_en(irq_en), .irq_clr(irq_clr), .conv_tick(conv_tick), .cmp_in(cmp_in),
      .dac_code(dac_code), .busy(busy), .result(result), .irq_flag(irq_flag),
      .wake_req(wake_req), .conv_powered(conv_powered));

   function automatic int exp_code(int v);
      int code = 0;
      for (int b = 7; b >= 0; b--) begin
         if (v >= (code | (1 << b))) code = code | (1 << b);
      end
      return code;
   endfunction

   task automatic step();
      @(posedge clk); #5;
   endtask

   task automatic chk(bit ok, string req, int act, int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, expv);
      end
   endtask

   task automatic pulse_go();
      go_set = 1'b1; step(); go_set = 1'b0;
   endtask

   task automatic ticks(int n, int gap);
      for (int i = 0; i < n; i++) begin
         repeat ($urandom_range(gap, 0)) step();
         conv_tick = 1'b1; step(); conv_tick = 1'b0;
      end
   endtask

   task automatic clear_irq();
      irq_clr = 1'b1; step(); irq_clr = 1'b0;
   endtask

   task automatic full_conv(int v, bit rc, int gap);
      vin = v;
      clk_sel = rc ? 2'b11 : 2'($urandom_range(2, 0));
      pulse_go();
      chk(busy == 1'b1, "R3 accepted start", busy, 1);
      if (rc) begin
         conv_tick = 1'b1; repeat (DLY) step(); conv_tick = 1'b0;
         chk(dac_code == 8'h00 && busy, "R5 rc wait ignores ticks", dac_code, 0);
      end
      ticks(1, gap);
      chk(dac_code == 8'h80, "R4 first trial code", dac_code, 128);
      ticks(8, gap);
      chk(busy == 1'b0, "R7 busy falls", busy, 0);
      chk(int'(result) == exp_code(v), "R6 result code", result, exp_code(v));
      chk(irq_flag == 1'b1, "R7 irq set", irq_flag, 1);
      clear_irq();
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 100000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
            finish_run();
         end
      end
   end

   initial begin
      int unsigned seed;
      int old;
      seed = $urandom(32'h5EED_0A3C);
      enable = 1'b1;
      repeat (3) step();
      // R1 / R2 reset state
      chk(busy == 0 && irq_flag == 0 && wake_req == 0, "R1 reset flags", busy, 0);
      chk(dac_code == 0, "R1 reset dac", dac_code, 0);
      chk(result == 0, "R2 power-on result", result, 0);
      rst_n = 1'b1; por_n = 1'b1; step();
      chk(conv_powered == 1'b1, "R1 powered follows enable", conv_powered, 1);

      // R6 directed corner codes
      full_conv(0, 0, 0);
      full_conv(255, 0, 0);
      full_conv(1, 0, 1);
      full_conv(128, 1, 0);
      full_conv(400, 0, 0);
      full_conv(127, 1, 2);

      // R6 random conversions
      for (int k = 0; k < 24; k++)
         full_conv(int'($urandom_range(260, 0)), 1'($urandom_range(1, 0)), 2);

      // R3 start ignored when disabled
      enable = 1'b0; pulse_go();
      chk(busy == 1'b0, "R3 start while disabled", busy, 0);
      enable = 1'b1; step();

      // R3 start ignored while busy
      vin = 100; clk_sel = 2'b01; pulse_go(); ticks(3, 0);
      vin = 20; pulse_go(); vin = 100;
      ticks(6, 0);
      chk(int'(result) == 100, "R3 restart ignored", result, 100);
      clear_irq();

      // R7 completion wins over irq_clr
      vin = 77; pulse_go(); ticks(8, 0);
      irq_clr = 1'b1; conv_tick = 1'b1; step(); irq_clr = 1'b0; conv_tick = 1'b0;
      chk(irq_flag == 1'b1, "R7 done beats clear", irq_flag, 1);
      clear_irq();
      chk(irq_flag == 1'b0, "R7 irq clear", irq_flag, 0);

      // R8 non-RC sleep aborts
      old = int'(result);
      vin = 200; clk_sel = 2'b10; pulse_go(); ticks(4, 0);
      sleep_enter = 1'b1; step(); sleep_enter = 1'b0;
      chk(busy == 0 && irq_flag == 0, "R8 abort flags", busy, 0);
      chk(int'(result) == old, "R8 result kept", result, old);
      chk(conv_powered == 0 && enable == 1, "R8 powered down", conv_powered, 0);
      sleep_exit = 1'b1; step(); sleep_exit = 1'b0;
      chk(conv_powered == 1'b1, "R12 sleep exit repowers", conv_powered, 1);

      // R9 RC sleep with interrupt enabled
      irq_en = 1'b1; vin = 45; clk_sel = 2'b11; pulse_go();
      sleep_enter = 1'b1; step(); sleep_enter = 1'b0;
      repeat (DLY - 1) step();
      ticks(9, 1);
      chk(int'(result) == 45, "R9 result through sleep", result, 45);
      chk(wake_req == 1'b1, "R9 wake request", wake_req, 1);
      step();
      chk(wake_req == 1'b1, "R9 wake held", wake_req, 1);
      sleep_exit = 1'b1; step(); sleep_exit = 1'b0;
      chk(wake_req == 1'b0, "R9 wake released", wake_req, 0);
      clear_irq();

      // R10 RC sleep with interrupt masked
      irq_en = 1'b0; vin = 210; pulse_go();
      sleep_enter = 1'b1; step(); sleep_enter = 1'b0;
      repeat (DLY - 1) step();
      ticks(9, 0);
      chk(irq_flag == 1 && wake_req == 0, "R10 flag without wake", wake_req, 0);
      chk(conv_powered == 1'b0, "R10 powered down", conv_powered, 0);
      chk(int'(result) == 210, "R10 result", result, 210);
      pulse_go();
      chk(conv_powered == 1'b1, "R12 start repowers", conv_powered, 1);
      ticks(9, 0);
      sleep_exit = 1'b1; step(); sleep_exit = 1'b0;
      clear_irq();

      // R12 enable low clears power-down
      clk_sel = 2'b00; sleep_enter = 1'b1; step(); sleep_enter = 1'b0;
      chk(conv_powered == 1'b0, "R8 idle non-RC sleep", conv_powered, 0);
      enable = 1'b0; step(); enable = 1'b1; step();
      chk(conv_powered == 1'b1, "R12 enable toggle repowers", conv_powered, 1);
      sleep_exit = 1'b1; step(); sleep_exit = 1'b0;

      // R11 abort and final decision on one edge
      old = int'(result);
      vin = 33; clk_sel = 2'b01; pulse_go(); ticks(8, 0);
      sleep_enter = 1'b1; conv_tick = 1'b1; step(); sleep_enter = 1'b0; conv_tick = 1'b0;
      chk(busy == 0 && irq_flag == 0, "R11 abort wins flags", irq_flag, 0);
      chk(int'(result) == old, "R11 result kept", result, old);
      sleep_exit = 1'b1; step(); sleep_exit = 1'b0;

      // R2 system reset mid-conversion keeps result
      full_conv(99, 0, 0);
      vin = 5; pulse_go(); ticks(5, 0);
      rst_n = 1'b0; step(); rst_n = 1'b1; step();
      chk(busy == 0 && dac_code == 0, "R2 reset aborts", busy, 0);
      chk(int'(result) == 99, "R2 reset keeps result", result, 99);
      chk(irq_flag == 0, "R1 reset irq", irq_flag, 0);

      finish_run();
   end

endmodule